// File: doc/BRIEF.md
# Dithered-Period Complementary PWM Generator

The block drives two complementary PWM outputs separated by dead time. One PWM cycle runs four phases in a fixed order: a gap with both outputs low, a window with output 0 high, a second gap with both outputs low, and a window with output 1 high. Each phase length in clocks comes from its own 12-bit input. With every phase input held constant, the period is fixed at n clocks, where n is the sum of the four phase values. The output frequency can then change only in steps between f_clk/n and f_clk/(n+1).

Enhanced mode groups cycles into frames of 16. A 4-bit dither value d lengthens d of those cycles by one clock. The longer cycles are spread evenly through the frame, so the frame-average frequency lies between the two neighbouring base frequencies. This makes frequency steps sixteen times finer. New phase lengths, dither value and mode are taken only at a frame boundary in enhanced mode, and only at a cycle boundary in normal mode. A partial frame therefore never mixes two settings. Strobes mark the last clock of every cycle and the last clock of every frame.

Top module: `dpwm_dither_gen`

## Requirements
- R1: Within a cycle at position p (0 at the first clock), output 0 is high exactly for dt0 <= p < dt0+ot0, and output 1 is high from p = dt0+ot0+dt1 to the last clock of the cycle.
- R2: In normal mode (mode input 0) every cycle lasts exactly dt0+ot0+dt1+ot1 clocks.
- R3: A phase whose value is 0 takes no clocks. If all four values are 0 and no stretch applies, the cycle lasts one clock with both outputs low.
- R4: The two PWM outputs are never high in the same clock.
- R5: In enhanced mode (mode input 1), cycle k of the frame (k = 0..15) is one clock longer exactly when the 4-bit bit-reverse of k is less than d. The extra clock extends the output-1 window, and the dead-time gaps keep their length.
- R6: An enhanced frame lasts 16*n + d clocks. With d = 0, no cycle is stretched.
- R7: The cycle-end strobe is high for exactly one clock, on the last clock of every cycle.
- R8: The frame-end strobe is high only on the last clock of frame cycle 15, and only in enhanced mode. It never pulses in normal mode.
- R9: Phase values, d and mode are captured when the block starts. After that they are captured on the last clock of a cycle in normal mode, or on the last clock of a frame in enhanced mode. Changes at other times have no effect until that point.
- R10: While the enable input is low (and at reset), both outputs and both strobes are low. After enable is seen high, the first cycle starts on the next clock at frame cycle 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable |
| enh_i | input | 1 | Mode: 0 normal, 1 enhanced (dithered) |
| dt0_i | input | 12 | Leading dead time in clocks |
| ot0_i | input | 12 | Output 0 on time in clocks |
| dt1_i | input | 12 | Second dead time in clocks |
| ot1_i | input | 12 | Output 1 on time in clocks |
| frac_i | input | 4 | Dither count d per 16-cycle frame |
| pwm0_o | output | 1 | PWM output 0 |
| pwm1_o | output | 1 | PWM output 1 (complementary) |
| cyc_end_o | output | 1 | Last clock of a cycle |
| frm_end_o | output | 1 | Last clock of a frame |

## Verification
A wrong position counter shows up within one cycle, as a changed cycle length or a shifted edge on either output. A wrong frame index or bit-reverse pattern shows up in the cycle where a long cycle is missing or out of place. It also shows up within one frame as a frame length other than 16*n + d, or as a frame strobe in the wrong cycle. A shadow register that captures at the wrong time shows up in the very next cycle, where the new timing appears while the old values should still apply.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int unsigned DPWM_TIME_W    = 12;
  localparam int unsigned DPWM_FRAME_LOG = 4;
endpackage

// File: rtl/dpwm_shadow.sv
module dpwm_shadow #(
  parameter int unsigned TW = 12,
  parameter int unsigned FL = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          enh_i,
  input  logic [TW-1:0] dt0_i,
  input  logic [TW-1:0] ot0_i,
  input  logic [TW-1:0] dt1_i,
  input  logic [TW-1:0] ot1_i,
  input  logic [FL-1:0] frac_i,
  output logic          enh_o,
  output logic [TW-1:0] dt0_o,
  output logic [TW-1:0] ot0_o,
  output logic [TW-1:0] dt1_o,
  output logic [TW-1:0] ot1_o,
  output logic [FL-1:0] frac_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enh_o  <= 1'b0;
      dt0_o  <= '0;
      ot0_o  <= '0;
      dt1_o  <= '0;
      ot1_o  <= '0;
      frac_o <= '0;
    end else if (load_i) begin
      enh_o  <= enh_i;
      dt0_o  <= dt0_i;
      ot0_o  <= ot0_i;
      dt1_o  <= dt1_i;
      ot1_o  <= ot1_i;
      frac_o <= frac_i;
    end
  end

  // R9
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(load_i) |-> ($stable(dt0_o) && $stable(ot0_o) && $stable(dt1_o) &&
                        $stable(ot1_o) && $stable(frac_o) && $stable(enh_o)));
endmodule

// File: rtl/dpwm_dither.sv
module dpwm_dither #(
  parameter int unsigned FL = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          enh_i,
  input  logic [FL-1:0] frac_i,
  input  logic          cyc_end_i,
  input  logic          load_i,
  output logic          stretch_o,
  output logic          last_cyc_o
);
  logic [FL-1:0] k_q;
  logic [FL-1:0] rev_k;

  for (genvar i = 0; i < FL; i++) begin : g_rev
    assign rev_k[i] = k_q[FL-1-i];
  end

  // frame index; a capture always restarts it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                k_q <= '0;
    else if (!run_i)            k_q <= '0;
    else if (cyc_end_i) begin
      if (load_i)               k_q <= '0;
      else                      k_q <= k_q + 1'b1;
    end
  end

  assign stretch_o  = enh_i && (rev_k < frac_i);
  assign last_cyc_o = &k_q;

  // R8
  normal_frame_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enh_i |-> (k_q == '0));
  // R6
  no_dither_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frac_i == '0) |-> !stretch_o);
endmodule

// File: rtl/dpwm_timer.sv
module dpwm_timer #(
  parameter int unsigned TW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [TW-1:0] dt0_i,
  input  logic [TW-1:0] ot0_i,
  input  logic [TW-1:0] dt1_i,
  input  logic [TW-1:0] ot1_i,
  input  logic          stretch_i,
  output logic          pwm0_o,
  output logic          pwm1_o,
  output logic          cyc_end_o
);
  localparam int unsigned PW = TW + 2;

  logic [PW-1:0] edge0, edge1, edge2, period, last, pos_q;

  always_comb begin
    edge0  = PW'(dt0_i);
    edge1  = edge0 + PW'(ot0_i);
    edge2  = edge1 + PW'(dt1_i);
    period = edge2 + PW'(ot1_i) + PW'(stretch_i);
    last   = (period == '0) ? '0 : period - 1'b1;
  end

  assign cyc_end_o = run_i && (pos_q == last);
  assign pwm0_o    = run_i && (pos_q >= edge0) && (pos_q < edge1);
  assign pwm1_o    = run_i && (pos_q >= edge2) && (pos_q < period);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pos_q <= '0;
    else if (!run_i)    pos_q <= '0;
    else if (cyc_end_o) pos_q <= '0;
    else                pos_q <= pos_q + 1'b1;
  end

  // R4
  no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pwm0_o && pwm1_o));
  // R7
  cyc_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_end_o |=> (pos_q == '0));
  // R2
  pos_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (pos_q <= last));
endmodule

// File: rtl/dpwm_dither_gen.sv
module dpwm_dither_gen
  import dpwm_pkg::*;
#(
  parameter int unsigned TW = DPWM_TIME_W,
  parameter int unsigned FL = DPWM_FRAME_LOG
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          enh_i,
  input  logic [TW-1:0] dt0_i,
  input  logic [TW-1:0] ot0_i,
  input  logic [TW-1:0] dt1_i,
  input  logic [TW-1:0] ot1_i,
  input  logic [FL-1:0] frac_i,
  output logic          pwm0_o,
  output logic          pwm1_o,
  output logic          cyc_end_o,
  output logic          frm_end_o
);
  logic          run_q, start, load;
  logic          enh_s, stretch, last_cyc;
  logic [TW-1:0] dt0_s, ot0_s, dt1_s, ot1_s;
  logic [FL-1:0] frac_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= en_i;
  end

  assign start     = en_i && !run_q;
  assign frm_end_o = cyc_end_o && enh_s && last_cyc;
  assign load      = start || (cyc_end_o && (!enh_s || last_cyc));

  dpwm_shadow #(.TW(TW), .FL(FL)) u_shadow (
    .clk_i, .rst_ni,
    .load_i (load),
    .enh_i, .dt0_i, .ot0_i, .dt1_i, .ot1_i, .frac_i,
    .enh_o  (enh_s),
    .dt0_o  (dt0_s),
    .ot0_o  (ot0_s),
    .dt1_o  (dt1_s),
    .ot1_o  (ot1_s),
    .frac_o (frac_s)
  );

  dpwm_dither #(.FL(FL)) u_dither (
    .clk_i, .rst_ni,
    .run_i      (run_q),
    .enh_i      (enh_s),
    .frac_i     (frac_s),
    .cyc_end_i  (cyc_end_o),
    .load_i     (load),
    .stretch_o  (stretch),
    .last_cyc_o (last_cyc)
  );

  dpwm_timer #(.TW(TW)) u_timer (
    .clk_i, .rst_ni,
    .run_i     (run_q),
    .dt0_i     (dt0_s),
    .ot0_i     (ot0_s),
    .dt1_i     (dt1_s),
    .ot1_i     (ot1_s),
    .stretch_i (stretch),
    .pwm0_o, .pwm1_o, .cyc_end_o
  );

  // R8
  frm_in_cyc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_end_o |-> cyc_end_o);
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> !(pwm0_o || pwm1_o || cyc_end_o || frm_end_o));
  // R10
  start_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !frm_end_o);
endmodule

// File: tb/dpwm_dither_gen_bench.sv
module dpwm_dither_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, enh = 1'b0;
  logic [11:0] dt0 = '0, ot0 = '0, dt1 = '0, ot1 = '0;
  logic [3:0] frac = '0;
  logic pwm0, pwm1, cyc_end, frm_end;

  int checks = 0, fails = 0;
  int poke_at = -1;
  int p_dt0, p_ot0, p_dt1, p_ot1, p_frac;
  bit p_enh;

  always #4 clk = ~clk;

  dpwm_dither_gen u_dpwm_dither_gen (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .enh_i(enh),
    .dt0_i(dt0), .ot0_i(ot0), .dt1_i(dt1), .ot1_i(ot1), .frac_i(frac),
    .pwm0_o(pwm0), .pwm1_o(pwm1), .cyc_end_o(cyc_end), .frm_end_o(frm_end)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rev4(input int k);
    return ((k & 1) << 3) | ((k & 2) << 1) | ((k & 4) >> 1) | ((k & 8) >> 3);
  endfunction

  task automatic set_cfg(input int a, b, c, d_, input int f, input bit e);
    dt0 = 12'(a); ot0 = 12'(b); dt1 = 12'(c); ot1 = 12'(d_); frac = 4'(f); enh = e;
  endtask

  // call at a negedge; next negedge samples the first clock of a cycle
  task automatic start_run(input int a, b, c, d_, input int f, input bit e);
    en = 1'b0;
    repeat (2) @(negedge clk);
    set_cfg(a, b, c, d_, f, e);
    en = 1'b1;
  endtask

  task automatic run_cycle(input int a, b, c, d_, input int s, input bit fe,
                           input string req, output int len);
    int n0 = 0, n1 = 0, f0 = -1, f1 = -1, fe_cnt = 0, fe_last = 0, both = 0;
    int exp_len;
    bit done = 0;
    len = 0;
    while (!done && len < 20000) begin
      @(negedge clk);
      if (pwm0) begin n0++; if (f0 < 0) f0 = len; end
      if (pwm1) begin n1++; if (f1 < 0) f1 = len; end
      if (pwm0 && pwm1) both++;
      if (frm_end) begin fe_cnt++; if (cyc_end) fe_last = 1; end
      if (len == poke_at) set_cfg(p_dt0, p_ot0, p_dt1, p_ot1, p_frac, p_enh);
      len++;
      if (cyc_end) done = 1;
    end
    exp_len = a + b + c + d_ + s;
    if (exp_len == 0) exp_len = 1;
    chk({req, " R2 R7"}, "cycle length", len, exp_len);
    chk({req, " R1"}, "out0 high clocks", n0, b);
    if (b > 0) chk({req, " R1"}, "out0 first high", f0, a);
    chk({req, " R5"}, "out1 high clocks", n1, d_ + s);
    if (d_ + s > 0) chk({req, " R1"}, "out1 first high", f1, a + b + c);
    chk("R4", "overlap clocks", both, 0);
    chk({req, " R8"}, "frame strobes", fe_cnt, fe ? 1 : 0);
    if (fe) chk("R8", "frame strobe on last clock", fe_last, 1);
  endtask

  task automatic run_frame(input int a, b, c, d_, input int dv, input int poke_k,
                           input string req);
    int tot = 0, l;
    for (int k = 0; k < 16; k++) begin
      poke_at = (k == poke_k) ? 1 : -1;
      run_cycle(a, b, c, d_, (rev4(k) < dv) ? 1 : 0, k == 15, req, l);
      tot += l;
    end
    poke_at = -1;
    chk({req, " R6"}, "frame length", tot, 16 * (a + b + c + d_) + dv);
  endtask

  task automatic test_reset;
    repeat (3) @(negedge clk);
    chk("R10", "reset outputs", {pwm0, pwm1, cyc_end, frm_end}, 0);
    rst_n = 1'b1;
    set_cfg(3, 5, 2, 4, 0, 0);
    repeat (4) @(negedge clk);
    chk("R10", "disabled outputs", {pwm0, pwm1, cyc_end, frm_end}, 0);
  endtask

  task automatic test_normal;
    int l;
    start_run(3, 5, 2, 4, 7, 0);
    for (int i = 0; i < 3; i++) run_cycle(3, 5, 2, 4, 0, 0, "normal", l);
    start_run(1, 1, 1, 1, 0, 0);
    for (int i = 0; i < 2; i++) run_cycle(1, 1, 1, 1, 0, 0, "normal small", l);
  endtask

  task automatic test_zero;
    int l;
    start_run(0, 4, 0, 0, 0, 0);
    run_cycle(0, 4, 0, 0, 0, 0, "R3 only ot0", l);
    start_run(0, 0, 2, 3, 0, 0);
    run_cycle(0, 0, 2, 3, 0, 0, "R3 no ot0", l);
    start_run(0, 0, 0, 0, 0, 0);
    run_cycle(0, 0, 0, 0, 0, 0, "R3 all zero", l);
    run_cycle(0, 0, 0, 0, 0, 0, "R3 all zero", l);
  endtask

  task automatic test_enhanced;
    start_run(3, 5, 2, 4, 5, 1);
    run_frame(3, 5, 2, 4, 5, -1, "R5 d5");
    run_frame(3, 5, 2, 4, 5, -1, "R5 d5 repeat");
    start_run(2, 3, 2, 3, 0, 1);
    run_frame(2, 3, 2, 3, 0, -1, "R6 d0");
    start_run(1, 2, 1, 0, 15, 1);
    run_frame(1, 2, 1, 0, 15, -1, "R5 d15 ot1 zero");
  endtask

  task automatic test_defer_normal;
    int l;
    start_run(3, 5, 2, 4, 0, 0);
    p_dt0 = 2; p_ot0 = 6; p_dt1 = 1; p_ot1 = 3; p_frac = 0; p_enh = 0;
    poke_at = 4;
    run_cycle(3, 5, 2, 4, 0, 0, "R9 normal old", l);
    poke_at = -1;
    run_cycle(2, 6, 1, 3, 0, 0, "R9 normal new", l);
  endtask

  task automatic test_defer_enh;
    start_run(3, 5, 2, 4, 3, 1);
    p_dt0 = 4; p_ot0 = 2; p_dt1 = 3; p_ot1 = 5; p_frac = 9; p_enh = 1;
    run_frame(3, 5, 2, 4, 3, 4, "R9 enh old");
    run_frame(4, 2, 3, 5, 9, -1, "R9 enh new");
  endtask

  task automatic test_mode_switch;
    int l;
    start_run(2, 2, 2, 2, 6, 0);
    p_dt0 = 2; p_ot0 = 2; p_dt1 = 2; p_ot1 = 2; p_frac = 6; p_enh = 1;
    poke_at = 3;
    run_cycle(2, 2, 2, 2, 0, 0, "R9 switch old", l);
    poke_at = -1;
    run_frame(2, 2, 2, 2, 6, -1, "R9 switch enh");
  endtask

  task automatic test_disable;
    int l;
    start_run(3, 5, 2, 4, 5, 1);
    for (int k = 0; k < 5; k++) run_cycle(3, 5, 2, 4, (rev4(k) < 5) ? 1 : 0, 0, "R10 pre", l);
    en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10", "outputs while disabled", {pwm0, pwm1, cyc_end, frm_end}, 0);
    end
    en = 1'b1;
    run_frame(3, 5, 2, 4, 5, -1, "R10 restart");
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_normal();
    test_zero();
    test_enhanced();
    test_defer_normal();
    test_defer_enh();
    test_mode_switch();
    test_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule